// File: doc/BRIEF.md
# Bus Master Address Retry Controller

This block runs one address tenure at a time for a snooping, split-transaction processor bus. It takes a request from the cache side. The request carries a transaction kind and a tag. The block raises the bus request and drives the address strobe for one cycle when the grant arrives. It then watches the retry and shared response lines during a fixed sampling window that belongs to that tenure. The data beats of the tenure are counted as they arrive.

When a retry lands inside the window, the block does four things:
- it cancels the tenure;
- it aborts any data tenure already under way and drops the beats received so far;
- it holds the bus request low while the retry line stays asserted;
- it queues the same request again.

A tenure that closes its window without a retry, and that has received all of its beats, is reported once on the completion port. The report carries the tag and the cache-line allocation. A read or atomic read allocates shared when the shared line was seen in the window, and exclusive when it was not. Every other kind allocates nothing.

Top module: `bus_retry_ctl`

## Requirements
- R1: While reset is asserted, `br_o`, `ts_o`, `dabort_o`, `done_valid_o` and `retry_pend_o` are 0 and `req_ready_o` is 1.
- R2: A request accepted in cycle N gives `br_o`=1 from cycle N+1. When the grant is sampled, `ts_o` is 1 for exactly the following cycle, and `br_o` falls in that same cycle.
- R3: The response window opens in the second cycle after the cycle in which `ts_o` is high. A retry sampled in the first cycle after `ts_o` is ignored.
- R4: The window closes after the cycle that follows the one in which `aack_i` is sampled. A retry sampled later than that is ignored, and the tenure completes normally.
- R5: A retry sampled inside the window gives `retry_pend_o`=1 and `br_o`=0 from the next cycle. `br_o` stays 0 while `artry_i` stays 1. `br_o` returns to 1 in the cycle after `artry_i` is first sampled 0.
- R6: If at least one data beat has been sampled by the cycle of the retry, that cycle included, `dabort_o` pulses high for exactly one cycle, together with the rise of `retry_pend_o`. With no beat, it stays 0.
- R7: Beats sampled during a cancelled tenure, or while a retry is pending, are discarded. The reissued tenure needs a full BEATS (default 4) new beats before it completes.
- R8: `done_valid_o` pulses for one cycle, carrying the request's tag. This happens only after the window has closed without a retry and BEATS beats have been counted.
- R9: A read (kind 2'b00) or atomic read (kind 2'b01) that sees `shd_i` inside the window and is not retried completes with allocation 2'b01 (shared).
- R10: A read or atomic read that does not see `shd_i` inside the window completes with allocation 2'b10 (exclusive).
- R11: A write (kind 2'b10) or other kind (2'b11) completes with allocation 2'b00, whatever `shd_i` did.
- R12: No completion is reported while `retry_pend_o` is 1. `retry_pend_o` falls in the cycle in which the reissued `ts_o` is high, and the reissued tenure completes with the original tag.
- R13: `shd_i` sampled before the window opens has no effect on the allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | New transaction offered |
| req_kind_i | input | 2 | Transaction kind: 00 read, 01 atomic read, 10 write, 11 other |
| req_tag_i | input | TAG_W | Transaction tag returned on completion |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| bus_grant_i | input | 1 | Address bus granted to this master |
| br_o | output | 1 | Bus request |
| ts_o | output | 1 | Address strobe, one cycle per tenure |
| aack_i | input | 1 | Address acknowledge |
| artry_i | input | 1 | Address retry response |
| shd_i | input | 1 | Shared response |
| dbeat_i | input | 1 | One data beat received this cycle |
| dabort_o | output | 1 | Abort pulse for a started data tenure |
| done_valid_o | output | 1 | Completion pulse |
| done_tag_o | output | TAG_W | Tag of the completed transaction |
| done_alloc_o | output | 2 | Allocation: 00 none, 01 shared, 10 exclusive |
| retry_pend_o | output | 1 | A retried tenure waits to be reissued |

## Verification
A faulty window age counter shows at the ports within two or three cycles of the strobe. An early retry then sets `retry_pend_o` when it should not, or a late retry is missed and the completion pulse arrives too early. A stale beat count or shared flag carried across a retry shows on the reissued tenure: it completes one or more cycles early, or it reports the wrong allocation. A bus request that comes back too soon after a retry is visible one cycle after the first cycle in which the retry line is still high.

// File: rtl/brh_pkg.sv
package brh_pkg;

    typedef enum logic [1:0] {
        KIND_READ   = 2'd0,
        KIND_RDATOM = 2'd1,
        KIND_WRITE  = 2'd2,
        KIND_OTHER  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ALLOC_NONE   = 2'd0,
        ALLOC_SHARED = 2'd1,
        ALLOC_EXCL   = 2'd2
    } alloc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_TEN  = 2'd2,
        ST_HOLD = 2'd3
    } state_e;

endpackage

// File: rtl/brh_window.sv
module brh_window #(
    parameter int OPEN_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_i,
    input  logic aack_i,
    output logic open_o,
    output logic resolved_o
);
    localparam int AGE_W = $clog2(OPEN_DLY + 1);

    typedef struct packed {
        logic             trk;
        logic [AGE_W-1:0] age;
        logic             acked;
        logic             closed;
    } win_t;

    win_t win_q, win_d;

    // age counts cycles since the strobe cycle; acked marks the last open cycle
    always_comb begin
        win_d = win_q;
        if (clear_i) begin
            win_d = '0;
        end else if (start_i) begin
            win_d     = '0;
            win_d.trk = 1'b1;
            win_d.age = AGE_W'(1);
        end else if (win_q.trk) begin
            if (win_q.age != AGE_W'(OPEN_DLY)) win_d.age = win_q.age + 1'b1;
            if (aack_i)                       win_d.acked  = 1'b1;
            if (win_q.acked)                  win_d.closed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign open_o     = win_q.trk && (win_q.age == AGE_W'(OPEN_DLY)) && !win_q.closed;
    assign resolved_o = win_q.trk && win_q.acked;

    AST_WIN_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !open_o); // R3

    AST_WIN_SHUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.trk && win_q.acked && !clear_i && !start_i) |=> !open_o); // R4

endmodule

// File: rtl/brh_alloc.sv
module brh_alloc
    import brh_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear_i,
    input  logic   sample_i,
    input  logic   shd_i,
    input  kind_e  kind_i,
    output alloc_e alloc_o
);
    logic seen_q, seen_d, seen_now;

    assign seen_now = seen_q || (sample_i && shd_i);

    always_comb begin
        seen_d = clear_i ? 1'b0 : seen_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    always_comb begin
        if (kind_i == KIND_READ || kind_i == KIND_RDATOM)
            alloc_o = seen_now ? ALLOC_SHARED : ALLOC_EXCL;
        else
            alloc_o = ALLOC_NONE;
    end

    AST_SHD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !seen_q); // R13

endmodule

// File: rtl/brh_beats.sv
module brh_beats #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    input  logic beat_i,
    output logic started_o,
    output logic full_o
);
    localparam int CNT_W = $clog2(BEATS + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             take;

    assign take = en_i && beat_i && (cnt_q != CNT_W'(BEATS));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)   cnt_d = '0;
        else if (take) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign started_o = (cnt_q != '0) || (en_i && beat_i);
    assign full_o    = (cnt_q == CNT_W'(BEATS)) ||
                       (take && (cnt_q == CNT_W'(BEATS - 1)));

    AST_BEATS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/bus_retry_ctl.sv
module bus_retry_ctl
    import brh_pkg::*;
#(
    parameter int TAG_W    = 8,
    parameter int BEATS    = 4,
    parameter int OPEN_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [1:0]       req_kind_i,
    input  logic [TAG_W-1:0] req_tag_i,
    output logic             req_ready_o,
    input  logic             bus_grant_i,
    output logic             br_o,
    output logic             ts_o,
    input  logic             aack_i,
    input  logic             artry_i,
    input  logic             shd_i,
    input  logic             dbeat_i,
    output logic             dabort_o,
    output logic             done_valid_o,
    output logic [TAG_W-1:0] done_tag_o,
    output logic [1:0]       done_alloc_o,
    output logic             retry_pend_o
);
    typedef struct packed {
        state_e           st;
        kind_e            kind;
        logic [TAG_W-1:0] tag;
        logic             br;
        logic             ts;
        logic             retry;
        logic             dabort;
        logic             done_v;
        logic [TAG_W-1:0] done_tag;
        alloc_e           done_alloc;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic   in_ten, win_open, win_resolved;
    logic   beats_started, beats_full;
    logic   retry_hit, complete, ten_clear;
    alloc_e alloc;

    assign in_ten    = (ctl_q.st == ST_TEN);
    assign retry_hit = in_ten && win_open && artry_i;
    assign complete  = in_ten && !retry_hit && win_resolved && beats_full;
    assign ten_clear = retry_hit || complete;

    brh_window #(.OPEN_DLY(OPEN_DLY)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ctl_q.ts),
        .clear_i    (ten_clear),
        .aack_i     (aack_i),
        .open_o     (win_open),
        .resolved_o (win_resolved)
    );

    brh_alloc u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (ten_clear),
        .sample_i (win_open),
        .shd_i    (shd_i),
        .kind_i   (ctl_q.kind),
        .alloc_o  (alloc)
    );

    brh_beats #(.BEATS(BEATS)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ten_clear),
        .en_i      (in_ten),
        .beat_i    (dbeat_i),
        .started_o (beats_started),
        .full_o    (beats_full)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ts     = 1'b0;
        ctl_d.dabort = 1'b0;
        ctl_d.done_v = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    ctl_d.kind = kind_e'(req_kind_i);
                    ctl_d.tag  = req_tag_i;
                    ctl_d.br   = 1'b1;
                    ctl_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_grant_i) begin
                    ctl_d.ts    = 1'b1;
                    ctl_d.br    = 1'b0;
                    ctl_d.retry = 1'b0;
                    ctl_d.st    = ST_TEN;
                end
            end
            ST_TEN: begin
                if (retry_hit) begin
                    ctl_d.retry  = 1'b1;
                    ctl_d.br     = 1'b0;
                    ctl_d.dabort = beats_started;
                    ctl_d.st     = ST_HOLD;
                end else if (complete) begin
                    ctl_d.done_v     = 1'b1;
                    ctl_d.done_tag   = ctl_q.tag;
                    ctl_d.done_alloc = alloc;
                    ctl_d.st         = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!artry_i) begin
                    ctl_d.br = 1'b1;
                    ctl_d.st = ST_REQ;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready_o  = (ctl_q.st == ST_IDLE);
    assign br_o         = ctl_q.br;
    assign ts_o         = ctl_q.ts;
    assign dabort_o     = ctl_q.dabort;
    assign done_valid_o = ctl_q.done_v;
    assign done_tag_o   = ctl_q.done_tag;
    assign done_alloc_o = ctl_q.done_alloc;
    assign retry_pend_o = ctl_q.retry;

    AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |=> !ts_o); // R2

    AST_RETRY_DROPS_BR: assert property (@(posedge clk) disable iff (!rst_n)
        retry_hit |=> (!br_o && retry_pend_o)); // R5

    AST_HOLD_KEEPS_BR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HOLD && artry_i) |=> !br_o); // R5

    AST_ABORT_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        dabort_o |-> retry_pend_o); // R6

    AST_NO_DONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pend_o |-> !done_valid_o); // R12

    AST_NONREAD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_o && (ctl_q.kind == KIND_WRITE || ctl_q.kind == KIND_OTHER))
        |-> (done_alloc_o == 2'b00)); // R11

endmodule

// File: tb/bus_retry_ctl_bench.sv
module bus_retry_ctl_bench;

    localparam int TAG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid_i;
    logic [1:0]       req_kind_i;
    logic [TAG_W-1:0] req_tag_i;
    logic             req_ready_o;
    logic             bus_grant_i;
    logic             br_o, ts_o;
    logic             aack_i, artry_i, shd_i, dbeat_i;
    logic             dabort_o, done_valid_o, retry_pend_o;
    logic [TAG_W-1:0] done_tag_o;
    logic [1:0]       done_alloc_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    bus_retry_ctl #(.TAG_W(TAG_W), .BEATS(4), .OPEN_DLY(2)) u_bus_retry_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_kind_i   (req_kind_i),
        .req_tag_i    (req_tag_i),
        .req_ready_o  (req_ready_o),
        .bus_grant_i  (bus_grant_i),
        .br_o         (br_o),
        .ts_o         (ts_o),
        .aack_i       (aack_i),
        .artry_i      (artry_i),
        .shd_i        (shd_i),
        .dbeat_i      (dbeat_i),
        .dabort_o     (dabort_o),
        .done_valid_o (done_valid_o),
        .done_tag_o   (done_tag_o),
        .done_alloc_o (done_alloc_o),
        .retry_pend_o (retry_pend_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of bus responses, then move to the next sampling point
    task automatic cyc(input logic a, input logic k, input logic s, input logic b);
        artry_i = a;
        aack_i  = k;
        shd_i   = s;
        dbeat_i = b;
        @(negedge clk);
        artry_i = 1'b0;
        aack_i  = 1'b0;
        shd_i   = 1'b0;
        dbeat_i = 1'b0;
    endtask

    task automatic issue(input logic [1:0] kind, input logic [TAG_W-1:0] tag);
        req_valid_i = 1'b1;
        req_kind_i  = kind;
        req_tag_i   = tag;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic grant();
        bus_grant_i = 1'b1;
        @(negedge clk);
        bus_grant_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req_valid_i = 1'b0; req_kind_i = '0; req_tag_i = '0; bus_grant_i = 1'b0;
        aack_i = 1'b0; artry_i = 1'b0; shd_i = 1'b0; dbeat_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 br", br_o, 0);
        chk("R1 ts", ts_o, 0);
        chk("R1 dabort", dabort_o, 0);
        chk("R1 done", done_valid_o, 0);
        chk("R1 retry_pend", retry_pend_o, 0);
        chk("R1 ready", req_ready_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_clean_read();
        issue(2'b00, 8'h11);
        chk("R2 br after accept", br_o, 1);
        chk("R2 ready low", req_ready_o, 0);
        grant();
        chk("R2 ts on", ts_o, 1);
        chk("R2 br falls with ts", br_o, 0);
        cyc(0, 0, 0, 0);
        chk("R2 ts one cycle", ts_o, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R8 no done before last beat", done_valid_o, 0);
        cyc(0, 0, 0, 1);
        chk("R8 done", done_valid_o, 1);
        chk("R8 tag", done_tag_o, 8'h11);
        chk("R10 exclusive", done_alloc_o, 2'b10);
        cyc(0, 0, 0, 0);
        chk("R8 done one cycle", done_valid_o, 0);
    endtask

    task automatic t_shared_read();
        issue(2'b00, 8'h22);
        grant();
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 1, 1, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R9 done", done_valid_o, 1);
        chk("R9 shared", done_alloc_o, 2'b01);
        cyc(0, 0, 0, 0);
    endtask

    task automatic t_early_ignored();
        issue(2'b01, 8'h33);
        grant();
        cyc(0, 0, 0, 0);
        cyc(1, 1, 1, 0);
        chk("R3 early retry ignored", retry_pend_o, 0);
        chk("R3 br stays low", br_o, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R3 done", done_valid_o, 1);
        chk("R13 early shd ignored", done_alloc_o, 2'b10);
        cyc(0, 0, 0, 0);
    endtask

    task automatic t_late_write();
        issue(2'b10, 8'h44);
        grant();
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 1, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 1);
        chk("R4 late retry ignored", retry_pend_o, 0);
        cyc(1, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R4 done", done_valid_o, 1);
        chk("R11 write alloc none", done_alloc_o, 2'b00);
        chk("R4 no abort", dabort_o, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic t_retry_no_data();
        issue(2'b00, 8'h55);
        grant();
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 0);
        chk("R5 retry pending", retry_pend_o, 1);
        chk("R5 br low", br_o, 0);
        chk("R6 no abort without beats", dabort_o, 0);
        chk("R12 no done", done_valid_o, 0);
        artry_i = 1'b1;
        cyc(1, 0, 0, 0);
        chk("R5 br held low", br_o, 0);
        cyc(1, 0, 0, 0);
        chk("R5 br held low 2", br_o, 0);
        cyc(0, 0, 0, 0);
        chk("R5 br back", br_o, 1);
        chk("R12 still pending", retry_pend_o, 1);
        grant();
        chk("R12 reissued ts", ts_o, 1);
        chk("R12 pending cleared", retry_pend_o, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R12 done after reissue", done_valid_o, 1);
        chk("R12 original tag", done_tag_o, 8'h55);
        chk("R10 exclusive after retry", done_alloc_o, 2'b10);
        cyc(0, 0, 0, 0);
    endtask

    task automatic t_retry_abort();
        issue(2'b00, 8'h66);
        grant();
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 1);
        cyc(1, 0, 0, 1);
        chk("R6 abort pulse", dabort_o, 1);
        chk("R6 retry with abort", retry_pend_o, 1);
        cyc(0, 0, 0, 1);
        chk("R6 abort one cycle", dabort_o, 0);
        chk("R5 br back", br_o, 1);
        grant();
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R7 old beats discarded", done_valid_o, 0);
        cyc(0, 0, 0, 1);
        chk("R7 done after full burst", done_valid_o, 1);
        chk("R7 tag", done_tag_o, 8'h66);
        cyc(0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_clean_read();
        t_shared_read();
        t_early_ignored();
        t_late_write();
        t_retry_no_data();
        t_retry_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule